// File: doc/BRIEF.md
# Virtual-Flux Nearest-Level Modulator

This block produces the inserted-module level for one phase of a cascaded multilevel converter. On every sample strobe it takes a signed reference voltage and the reciprocal of the nominal per-module DC voltage. It adds the normalised reference to a carried residue, rounds the sum to the nearest integer level, and limits that level to the range the phase can produce. What rounding leaves behind is kept as the residue for the next sample.

Because the residue is carried from one sample to the next, the running integral of reference minus applied voltage stays small. The block therefore acts as a first-order noise shaper. In each period only one module toggles between adjacent levels, and the rest follow a slow staircase. The level output goes to the module-selection logic, which is not part of this block.

Top module: `vfm_level_gen`

## Requirements
- R1: After reset, level_o is 0, valid_o is 0 and the residue is 0. Seen at the ports: two samples of +0.25 level after reset give levels 0, then 1.
- R2: valid_o is high in exactly the cycle after a cycle with sample_i high. level_o takes its new value in that same cycle.
- R3: The unrounded value equals the residue plus ref_i × udc_recip_i / 65536. ref_i is two's complement. udc_recip_i is unsigned with 16 fraction bits and equals 65536 divided by the module voltage.
- R4: The unrounded value is rounded to the nearest integer. An exact half rounds away from zero, so +0.5 gives +1 and −0.5 gives −1.
- R5: The new residue is the unrounded value minus the emitted level. It always stays within ±0.5 level.
- R6: The level saturates at ±N_MOD, which is ±4 by default. On saturation the residue is clamped to ±0.5, so the accumulated excess is discarded.
- R7: With a slowly varying sinusoidal reference that stays inside the level range, successive levels differ by at most 1. The running sum of (reference/Udc − level) stays within ±1 level.
- R8: While sample_i is low, level_o holds its value and ref_i and udc_recip_i have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample strobe, one cycle per interrupt |
| ref_i | input | 16 | Signed reference voltage |
| udc_recip_i | input | 16 | Unsigned reciprocal of the module DC voltage, 16 fraction bits |
| level_o | output | 4 | Signed inserted level, −N_MOD to +N_MOD |
| valid_o | output | 1 | High for the cycle in which level_o has just been updated |

## Verification
A corrupted residue does not show at once. It first appears at the next sample strobe, as a level one step away from the expected value, for example a tie that rounds the wrong way or a non-zero level after a saturation. After that it either dies out or keeps the running flux sum above one level. Every level is therefore compared against a fixed-point model on the strobe that produced it. The sine run accumulates the flux error, so a slow drift is caught within a fraction of a period.

// File: rtl/vfm_pkg.sv
package vfm_pkg;
  localparam int unsigned REF_W_DEF   = 16;
  localparam int unsigned RECIP_W_DEF = 16;
  localparam int unsigned FRAC_W_DEF  = 16;
  localparam int unsigned N_MOD_DEF   = 4;

  function automatic int unsigned lvl_width(input int unsigned n);
    return $clog2(n + 1) + 1;
  endfunction
endpackage

// File: rtl/vfm_scale.sv
module vfm_scale #(
  parameter int unsigned REF_W   = 16,
  parameter int unsigned RECIP_W = 16,
  parameter int unsigned RES_W   = 18,
  parameter int unsigned ACC_W   = 34
) (
  input  logic [REF_W-1:0]        ref_i,
  input  logic [RECIP_W-1:0]      recip_i,
  input  logic signed [RES_W-1:0] residue_i,
  output logic signed [ACC_W-1:0] unrounded_o
);
  localparam int unsigned PROD_W = REF_W + RECIP_W + 1;

  logic signed [PROD_W-1:0] ref_x;
  logic signed [PROD_W-1:0] recip_x;
  logic signed [PROD_W-1:0] prod;

  assign ref_x   = PROD_W'($signed(ref_i));
  assign recip_x = PROD_W'({1'b0, recip_i});
  assign prod    = ref_x * recip_x;

  assign unrounded_o = ACC_W'(prod) + ACC_W'(residue_i);
endmodule

// File: rtl/vfm_round_sat.sv
module vfm_round_sat #(
  parameter int unsigned ACC_W  = 34,
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned N_MOD  = 4,
  parameter int unsigned LVL_W  = 4
) (
  input  logic signed [ACC_W-1:0] x_i,
  output logic signed [LVL_W-1:0] level_o
);
  localparam int unsigned MAG_W = ACC_W - FRAC_W;
  localparam logic [ACC_W-1:0] HALF_U = ACC_W'(1) << (FRAC_W - 1);

  logic             neg;
  logic [ACC_W-1:0] mag;
  logic [ACC_W-1:0] mag_rnd;
  logic [MAG_W-1:0] int_mag;
  logic             sat;
  logic [LVL_W-1:0] lvl_mag;

  // round magnitude so ties move away from zero
  always_comb begin
    neg     = x_i[ACC_W-1];
    mag     = neg ? ACC_W'(-x_i) : ACC_W'(x_i);
    mag_rnd = mag + HALF_U;
    int_mag = mag_rnd[ACC_W-1:FRAC_W];
    sat     = int_mag > MAG_W'(N_MOD);
    lvl_mag = sat ? LVL_W'(N_MOD) : int_mag[LVL_W-1:0];
    level_o = neg ? -$signed(lvl_mag) : $signed(lvl_mag);
  end
endmodule

// File: rtl/vfm_residue.sv
module vfm_residue #(
  parameter int unsigned ACC_W  = 34,
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned LVL_W  = 4,
  parameter int unsigned RES_W  = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] x_i,
  input  logic signed [LVL_W-1:0] level_i,
  output logic signed [RES_W-1:0] residue_o
);
  localparam logic signed [ACC_W-1:0] HALF_A = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [RES_W-1:0] HALF_R = RES_W'(1) <<< (FRAC_W - 1);

  logic signed [ACC_W-1:0] lvl_ext;
  logic signed [ACC_W-1:0] diff;
  logic signed [RES_W-1:0] residue_d;
  logic signed [RES_W-1:0] residue_q;

  always_comb begin
    lvl_ext = ACC_W'(level_i) <<< FRAC_W;
    diff    = x_i - lvl_ext;
    // clamp only bites on saturation; stops wind-up
    if (diff > HALF_A)       residue_d = HALF_R;
    else if (diff < -HALF_A) residue_d = -HALF_R;
    else                     residue_d = RES_W'(diff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   residue_q <= '0;
    else if (en_i) residue_q <= residue_d;
  end

  assign residue_o = residue_q;

  // R5
  residue_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (residue_q <= HALF_R) && (residue_q >= -HALF_R));
endmodule

// File: rtl/vfm_level_gen.sv
module vfm_level_gen #(
  parameter int unsigned REF_W   = vfm_pkg::REF_W_DEF,
  parameter int unsigned RECIP_W = vfm_pkg::RECIP_W_DEF,
  parameter int unsigned FRAC_W  = vfm_pkg::FRAC_W_DEF,
  parameter int unsigned N_MOD   = vfm_pkg::N_MOD_DEF,
  localparam int unsigned LVL_W  = vfm_pkg::lvl_width(N_MOD)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_i,
  input  logic [REF_W-1:0]        ref_i,
  input  logic [RECIP_W-1:0]      udc_recip_i,
  output logic signed [LVL_W-1:0] level_o,
  output logic                    valid_o
);
  localparam int unsigned ACC_W = REF_W + RECIP_W + 2;
  localparam int unsigned RES_W = FRAC_W + 2;
  localparam logic signed [LVL_W-1:0] N_POS = LVL_W'(N_MOD);

  logic signed [RES_W-1:0] residue;
  logic signed [ACC_W-1:0] unrounded;
  logic signed [LVL_W-1:0] level_d;
  logic signed [LVL_W-1:0] level_q;
  logic                    valid_q;

  vfm_scale #(
    .REF_W(REF_W), .RECIP_W(RECIP_W), .RES_W(RES_W), .ACC_W(ACC_W)
  ) u_scale (
    .ref_i(ref_i), .recip_i(udc_recip_i), .residue_i(residue), .unrounded_o(unrounded)
  );

  vfm_round_sat #(
    .ACC_W(ACC_W), .FRAC_W(FRAC_W), .N_MOD(N_MOD), .LVL_W(LVL_W)
  ) u_round (
    .x_i(unrounded), .level_o(level_d)
  );

  vfm_residue #(
    .ACC_W(ACC_W), .FRAC_W(FRAC_W), .LVL_W(LVL_W), .RES_W(RES_W)
  ) u_residue (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(sample_i),
    .x_i(unrounded), .level_i(level_d), .residue_o(residue)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= sample_i;
      if (sample_i) level_q <= level_d;
    end
  end

  assign level_o = level_q;
  assign valid_o = valid_q;

  // R6
  level_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q <= N_POS) && (level_q >= -N_POS));

  // R2
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |=> valid_o);

  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> !valid_o);

  // R8
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(level_o));
endmodule

// File: tb/vfm_level_gen_tb_top.sv
`timescale 1ns/1ps
module vfm_level_gen_tb_top;
  localparam int N_MOD = 4;
  localparam longint ONE  = 65536;
  localparam longint HALF = 32768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample = 1'b0;
  logic [15:0] ref_v = '0;
  logic [15:0] recip = '0;
  logic signed [3:0] level;
  logic        valid;

  int     n_chk = 0;
  int     n_bad = 0;
  bit     done  = 1'b0;
  longint m_res = 0;
  int     m_lvl = 0;

  always #2 clk = ~clk;

  vfm_level_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .ref_i(ref_v),
    .udc_recip_i(recip), .level_o(level), .valid_o(valid)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // fixed-point expectation: nearest, half away from zero, saturate, clamp residue
  function automatic void model_step(input int r, input int rc);
    longint x, mag, im, d;
    x   = m_res + longint'(r) * longint'(rc);
    mag = (x < 0) ? -x : x;
    im  = (mag + HALF) / ONE;
    if (im > N_MOD) im = N_MOD;
    m_lvl = int'((x < 0) ? -im : im);
    d = x - longint'(m_lvl) * ONE;
    if (d > HALF) d = HALF;
    else if (d < -HALF) d = -HALF;
    m_res = d;
  endfunction

  task automatic do_sample(input int r, input int rc, input string tag);
    @(negedge clk);
    sample = 1'b1;
    ref_v  = 16'(r);
    recip  = 16'(rc);
    model_step(r, rc);
    @(negedge clk);
    sample = 1'b0;
    check({tag, " valid"}, longint'(valid), 1);
    check({tag, " level"}, longint'($signed(level)), longint'(m_lvl));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sample = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_res = 0;
    m_lvl = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R1 reset state
    check("R1 level after reset", longint'($signed(level)), 0);
    check("R1 valid after reset", longint'(valid), 0);
    // R1 residue starts at 0: 0.25 -> 0, then 0.5 -> 1
    do_sample(1, 16384, "R1 first");
    do_sample(1, 16384, "R4 tie +0.5");
    // R4 negative tie: residue -0.5 with zero reference
    do_sample(0, 16384, "R4 tie -0.5");
    // R8 hold while sample low, R2 valid low
    @(negedge clk);
    ref_v = 16'd30000;
    recip = 16'd65535;
    repeat (3) @(negedge clk);
    check("R8 level hold", longint'($signed(level)), -1);
    check("R2 valid idle", longint'(valid), 0);
    // R6 positive and negative saturation with residue clamp
    do_sample(1000, 65535, "R6 sat +");
    do_sample(0, 65535, "R6 clamp +");
    do_sample(-1000, 65535, "R6 sat -");
    do_sample(0, 65535, "R6 clamp -");
    // R3 scaling with carried residue
    do_sample(100, 1500, "R3 scale a");
    do_sample(100, 1500, "R3 scale b");
    do_sample(-37, 4000, "R3 scale c");
    // R5 random mix, back-to-back and spaced samples
    for (int i = 0; i < 400; i++) begin
      int r, rc;
      r  = int'($signed(16'($urandom)));
      if ($urandom_range(0, 3) != 0) r = r % 400;
      rc = int'($urandom_range(0, 2000));
      do_sample(r, rc, "R5 random");
      if ($urandom_range(0, 1) != 0) repeat ($urandom_range(1, 4)) @(negedge clk);
    end
    // R1 mid-run reset
    do_reset();
    check("R1 level after re-reset", longint'($signed(level)), 0);
    // R7 sine tracking, 3.5 level amplitude, 400 samples per period
    begin
      longint flux;
      int prev, step_bad, flux_bad;
      flux = 0; prev = 0; step_bad = 0; flux_bad = 0;
      for (int k = 0; k < 800; k++) begin
        int r, lv;
        r = $rtoi(2800.0 * $sin(6.283185307179586 * k / 400.0));
        do_sample(r, 82, "R7 sine");
        lv = int'($signed(level));
        if (lv - prev > 1 || prev - lv > 1) step_bad++;
        flux += longint'(r) * 82 - longint'(lv) * ONE;
        if (flux > ONE || flux < -ONE) flux_bad++;
        prev = lv;
      end
      check("R7 step limit violations", step_bad, 0);
      check("R7 flux bound violations", flux_bad, 0);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule